// File: doc/BRIEF.md
# Tick Timer with Rollover Count and Interrupt Request

This block is a 32-bit up-counting tick timer. When a count passes the all-ones value, the counter takes a programmable start value again. Each such wrap raises a carry. The carry advances a 4-bit rollover tally. If interrupts are enabled, the carry also latches a pending flag, and the flag drives a 3-bit interrupt request level toward the system interrupt logic.

Software controls the timer through a small synchronous register port with an address, a write strobe, write data and combinational read data. There are four word addresses:

- 0: control
- 1: interrupt control
- 2: start value
- 3: live count readback

Clearing the run bit parks the counter on the start value. A separate count-enable bit freezes and resumes the counter without changing its value. Software clears the pending flag by writing a 1 to it, which avoids a read-modify-write race.

Top module: `tick_timer`

## Requirements
- R1: After reset, all four addresses read zero, and `irq_o` is zero.
- R2: While control bit 0 (run) is 0, the counter loads the start value (address 2) on every clock. Its readback equals the start value that was stored one cycle earlier.
- R3: With run = 1 and control bit 1 (count enable) = 1, the counter rises by one on each clock.
- R4: With run = 1 and count enable = 0, the counter holds its value. Setting count enable to 1 again resumes counting from the held value.
- R5: When the counter is at all ones and counting, the next clock loads the start value into it.
- R6: Each rollover increments a 4-bit tally, which reads on control bits 7:4. The tally wraps from 15 to 0.
- R7: Writing 1 to control bit 2 clears the tally, and this bit always reads 0. If the clear and a rollover fall in the same cycle, the clear wins.
- R8: Interrupt control bit 7 (pending) becomes 1 only on a rollover while interrupt control bit 3 (enable) is 1. Rollovers that happen with enable = 0 leave pending at 0.
- R9: Writing 1 to bit 7 of interrupt control clears pending, and writing 0 to it leaves pending unchanged. If the write-1 clear and a rollover fall in the same cycle, pending stays 1.
- R10: A write that sets enable to 0 clears pending on that same edge. Turning enable back on does not set pending until the next rollover.
- R11: `irq_o` equals interrupt control bits 2:0 (level) while pending is 1 and the level is nonzero. Otherwise `irq_o` is 0, so level 0 serves software polling.
- R12: Writes to address 3 have no effect on the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe |
| addr_i | input | 2 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 3 | Interrupt request level, 0 means none |

## Verification
Two pairs of events can land on the same clock edge:

- A counter rollover and a software clear of the rollover tally.
- A rollover and a write-1 clear of the pending flag.

The bench uses a start value six counts below the top of the range. From a known start value it counts edges exactly and times each clearing write to hit the rollover edge. It then checks that the tally reads 0 and that pending reads 1 with `irq_o` at the programmed level. A long sweep of edge counts compares the counter and the tally against values computed modulo the six-count period, so the tally passes its 15-to-0 wrap inside the sweep.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL    = 2'd0,
    A_IRQ     = 2'd1,
    A_PRELOAD = 2'd2,
    A_COUNT   = 2'd3
  } reg_addr_e;

  // control register
  localparam int CTL_RUN  = 0;
  localparam int CTL_EN   = 1;
  localparam int CTL_CLR  = 2;
  localparam int CTL_OVF0 = 4;
  // interrupt control register
  localparam int IRQ_LVL0 = 0;
  localparam int IRQ_IE   = 3;
  localparam int IRQ_PEND = 7;
endpackage

// File: rtl/tick_regs.sv
module tick_regs
  import tick_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              run_o,
  output logic              cnt_en_o,
  output logic [DATA_W-1:0] preload_o,
  output logic              ovf_clr_o,
  output logic              irq_we_o
);
  logic ctl_we, pre_we;

  always_comb begin
    ctl_we    = we_i && (addr_i == A_CTRL);
    pre_we    = we_i && (addr_i == A_PRELOAD);
    irq_we_o  = we_i && (addr_i == A_IRQ);
    ovf_clr_o = ctl_we && wdata_i[CTL_CLR];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o    <= 1'b0;
      cnt_en_o <= 1'b0;
    end else if (ctl_we) begin
      run_o    <= wdata_i[CTL_RUN];
      cnt_en_o <= wdata_i[CTL_EN];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     preload_o <= '0;
    else if (pre_we) preload_o <= wdata_i;
  end
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             cnt_en_i,
  input  logic [CNT_W-1:0] preload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             carry_o
);
  logic [CNT_W-1:0] cnt_q;

  always_comb carry_o = run_i && cnt_en_i && (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!run_i)    cnt_q <= preload_i;
    else if (cnt_en_i)  cnt_q <= carry_o ? preload_i : cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tick_ovf.sv
module tick_ovf #(
  parameter int OVF_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [OVF_W-1:0] ovf_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ovf_o <= '0;
    else if (clr_i)  ovf_o <= '0;  // clear beats a same-cycle rollover
    else if (inc_i)  ovf_o <= ovf_o + OVF_W'(1);
  end
endmodule

// File: rtl/tick_irq.sv
module tick_irq #(
  parameter int LVL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [LVL_W-1:0] lvl_wdata_i,
  input  logic             ie_wdata_i,
  input  logic             w1c_i,
  input  logic             carry_i,
  output logic [LVL_W-1:0] level_o,
  output logic             ie_o,
  output logic             pend_o,
  output logic [LVL_W-1:0] irq_o
);
  logic ie_d, pend_d;

  always_comb begin
    ie_d   = we_i ? ie_wdata_i : ie_o;
    // set on carry only if enabled now; disabling write clears at once
    pend_d = ie_d && ((pend_o && !(we_i && w1c_i)) || (carry_i && ie_o));
    irq_o  = (pend_o && (level_o != '0)) ? level_o : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_o <= '0;
      ie_o    <= 1'b0;
      pend_o  <= 1'b0;
    end else begin
      if (we_i) level_o <= lvl_wdata_i;
      ie_o   <= ie_d;
      pend_o <= pend_d;
    end
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int OVF_W = 4,
  parameter int LVL_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic [LVL_W-1:0]  irq_o
);
  localparam int DATA_W = CNT_W;

  logic              run_q, cnt_en_q, ovf_clr, irq_we, carry;
  logic              ie_q, pend_q;
  logic [DATA_W-1:0] preload_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [OVF_W-1:0]  ovf_q;
  logic [LVL_W-1:0]  level_q;

  tick_regs #(.DATA_W(DATA_W)) regs_i (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .run_o(run_q), .cnt_en_o(cnt_en_q), .preload_o(preload_q),
    .ovf_clr_o(ovf_clr), .irq_we_o(irq_we)
  );

  tick_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk_i, .rst_ni, .run_i(run_q), .cnt_en_i(cnt_en_q),
    .preload_i(preload_q), .cnt_o(cnt_q), .carry_o(carry)
  );

  tick_ovf #(.OVF_W(OVF_W)) ovf_i (
    .clk_i, .rst_ni, .clr_i(ovf_clr), .inc_i(carry), .ovf_o(ovf_q)
  );

  tick_irq #(.LVL_W(LVL_W)) irq_i (
    .clk_i, .rst_ni, .we_i(irq_we),
    .lvl_wdata_i(wdata_i[IRQ_LVL0 +: LVL_W]),
    .ie_wdata_i(wdata_i[IRQ_IE]), .w1c_i(wdata_i[IRQ_PEND]),
    .carry_i(carry), .level_o(level_q), .ie_o(ie_q), .pend_o(pend_q),
    .irq_o
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: begin
        rdata_o[CTL_RUN]              = run_q;
        rdata_o[CTL_EN]               = cnt_en_q;
        rdata_o[CTL_OVF0 +: OVF_W]    = ovf_q;
      end
      A_IRQ: begin
        rdata_o[IRQ_LVL0 +: LVL_W]    = level_q;
        rdata_o[IRQ_IE]               = ie_q;
        rdata_o[IRQ_PEND]             = pend_q;
      end
      A_PRELOAD: rdata_o              = preload_q;
      default:   rdata_o              = cnt_q;
    endcase
  end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int CNT_W = 32,
  parameter int OVF_W = 4,
  parameter int LVL_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_q,
  input logic             cnt_en_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] preload_q,
  input logic [OVF_W-1:0] ovf_q,
  input logic             ovf_clr,
  input logic             carry,
  input logic             ie_q,
  input logic             pend_q,
  input logic [LVL_W-1:0] irq_o
);
  AST_LOAD_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |=> cnt_q == $past(preload_q)); // R2
  AST_COUNT_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt_en_q && cnt_q != '1) |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R3
  AST_HOLD_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !cnt_en_q) |=> $stable(cnt_q)); // R4
  AST_ROLL_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt_en_q && cnt_q == '1) |=> cnt_q == $past(preload_q)); // R5
  AST_OVF_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_clr |=> ovf_q == '0); // R7
  AST_PEND_FROM_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(carry && ie_q)); // R8
  AST_PEND_NEEDS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> ie_q); // R10
  AST_IRQ_ONLY_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != '0) |-> pend_q); // R11
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W), .OVF_W(OVF_W), .LVL_W(LVL_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_q(run_q), .cnt_en_q(cnt_en_q),
  .cnt_q(cnt_q), .preload_q(preload_q), .ovf_q(ovf_q), .ovf_clr(ovf_clr),
  .carry(carry), .ie_q(ie_q), .pend_q(pend_q), .irq_o(irq_o)
);

// File: tb/tick_timer_tb_top.sv
module tick_timer_tb_top;
  localparam logic [31:0] P   = 32'hFFFF_FFFA;  // six-count period
  localparam int          PER = 6;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [2:0]  irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  tick_timer dut_i (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] v);
    addr_i = a;
    #1 v = rdata_o;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic tick(int n);
    repeat (n) begin @(posedge clk_i); @(negedge clk_i); end
  endtask

  task automatic irq_chk(string req, logic [31:0] reg_exp, logic [2:0] irq_exp);
    logic [31:0] v;
    rd(2'd1, v);
    chk(req, v, reg_exp);
    chk(req, {29'd0, irq_o}, {29'd0, irq_exp});
  endtask

  initial begin
    logic [31:0] v, v0;
    #5;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v); chk("R1", v, 32'd0);
    end
    chk("R1", {29'd0, irq_o}, 32'd0);
    @(negedge clk_i); rst_ni = 1'b1; @(negedge clk_i);

    // R2: parked counter follows start value
    wr(2'd2, P); tick(1);
    rd(2'd3, v); chk("R2", v, P);

    // R3 R5 R6: sweep counts across tally wrap
    wr(2'd0, 32'h3);
    for (int n = 1; n <= 120; n++) begin
      tick(1);
      rd(2'd3, v); chk("R3/R5", v, P + 32'(n % PER));
      rd(2'd0, v); chk("R6", {28'd0, v[7:4]}, 32'((n / PER) % 16));
    end

    // R4: stop holds, restart resumes
    wr(2'd0, 32'h1);
    rd(2'd3, v0); tick(5);
    rd(2'd3, v); chk("R4", v, v0);
    wr(2'd0, 32'h3);
    rd(2'd3, v); chk("R4", v, v0);
    tick(1);
    rd(2'd3, v); chk("R4", v, (v0 == 32'hFFFF_FFFF) ? P : v0 + 1);

    // R7: clear, and clear against rollover
    wr(2'd0, 32'h4);
    rd(2'd0, v); chk("R7", v, 32'h0);
    tick(1);
    wr(2'd0, 32'h3); tick(5);
    rd(2'd3, v); chk("R5", v, 32'hFFFF_FFFF);
    wr(2'd0, 32'h7);
    rd(2'd0, v); chk("R7", v, 32'h3);
    rd(2'd3, v); chk("R5", v, P);
    tick(6);
    rd(2'd0, v); chk("R6", v, 32'h13);

    // R8 R11: pending from rollover only when enabled
    wr(2'd0, 32'h0); wr(2'd1, 32'h0D); wr(2'd0, 32'h3);
    irq_chk("R8", 32'h0D, 3'd0);
    tick(5);
    irq_chk("R8", 32'h0D, 3'd0);
    tick(1);
    irq_chk("R8/R11", 32'h8D, 3'd5);

    // R9: write-0 keeps, write-1 clears, clash keeps set
    wr(2'd1, 32'h0D);
    irq_chk("R9", 32'h8D, 3'd5);
    wr(2'd1, 32'h8D);
    irq_chk("R9", 32'h0D, 3'd0);
    tick(3);
    irq_chk("R9", 32'h0D, 3'd0);
    wr(2'd1, 32'h8D);
    irq_chk("R9", 32'h8D, 3'd5);

    // R11 level 0 polling; R10 disable clears
    wr(2'd1, 32'h08);
    irq_chk("R11", 32'h88, 3'd0);
    wr(2'd1, 32'h00);
    irq_chk("R10", 32'h00, 3'd0);
    tick(12);
    irq_chk("R8", 32'h00, 3'd0);
    wr(2'd1, 32'h0B);
    irq_chk("R10", 32'h0B, 3'd0);
    tick(6);
    irq_chk("R8", 32'h8B, 3'd3);
    for (int l = 0; l < 8; l++) begin
      wr(2'd1, 32'h08 | 32'(l));
      irq_chk("R11", 32'h88 | 32'(l), 3'(l));
    end

    // R12: count address not writable
    wr(2'd0, 32'h1);
    rd(2'd3, v0);
    wr(2'd3, 32'h1234_5678);
    rd(2'd3, v); chk("R12", v, v0);
    tick(2);
    rd(2'd3, v); chk("R12", v, v0);

    // R2: follows a changed start value
    wr(2'd2, 32'h55); wr(2'd0, 32'h0); tick(1);
    rd(2'd3, v); chk("R2", v, 32'h55);
    wr(2'd2, 32'h66); tick(1);
    rd(2'd3, v); chk("R2", v, 32'h66);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule